// File: doc/BRIEF.md
# Dual-Channel Programmable Timer

This block is a memory-mapped peripheral that holds two independent counting channels. Each channel has a control word, a load value and a live counter. Software programs the channels through a plain register port. A write takes effect on the clock edge on which it is presented. A read returns data combinationally for the address currently on the port.

Each channel counts up or down by one per clock while it runs. It can be forced to its load value and held there. At terminal count it either reloads and keeps going, which gives a periodic tick when counting down or a free-running counter when counting up, or it stops itself. Terminal count raises a sticky event flag, and a single registered interrupt line reports any flag whose interrupt is enabled. One bit of the control word starts every channel in the same cycle. The control word also has mode, external-pin and pulse-width bits that are stored and read back but do nothing.

Top module: `duo_tick_timer`

## Requirements
- R1: After reset, every control, load and counter register reads as zero, and `irq` is low.
- R2: Channel n occupies byte offsets n*0x10: control at +0x0, load at +0x4, counter at +0x8. Control and load read back what was written, with the load value truncated to the counter width. Writes to a counter offset are ignored. Reads at offset +0xC, or at any address whose two low bits are not zero, return zero.
- R3: Control bit 7 runs the channel. While bit 7 is set and bit 5 is clear, the counter steps by one each clock: downward when bit 1 is 1, upward when bit 1 is 0.
- R4: While control bit 5 is set, the counter takes the load value on every clock and does not count.
- R5: When bit 7 is clear, the counter keeps its value.
- R6: Terminal count is 0 when counting down and all ones when counting up. A running channel at terminal count sets the flag, bit 8. With bit 4 set, the counter then takes the load value and the channel keeps running, so a down-count period is load+1 clocks.
- R7: With bit 4 clear, a channel that reaches terminal count clears its own bit 7 and holds the terminal value.
- R8: Writing a control word with bit 8 = 1 clears the flag. Writing it with bit 8 = 0 leaves the flag unchanged.
- R9: Any control write with bit 10 set sets bit 7 of every channel on the same edge.
- R10: `irq` is a register of the OR over channels of (bit 8 AND bit 6). It rises one clock after such a flag is set and falls one clock after it is cleared. The flag is set whether or not bit 6 is set.
- R11: Control bits 0, 2, 3 and 9 are stored and read back and have no effect on counting.
- R12: Writes and events on one channel leave the registers of the other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | AW (5 by default) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one access per clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Registered combined interrupt |

## Verification
The bench builds the block with two channels and `CNT_W` = 12. At that width, the all-ones terminal count of the up direction is reached within about four thousand clocks. This brings both the stop-at-terminal case and a full free-running wrap with reload within reach of a short run, while the decode and control logic stay as they are at the 32-bit default. The down-count tick, the cycle-exact interrupt latency, the acknowledge rules and the simultaneous start are all checked at this width.

// File: rtl/duo_tick_pkg.sv
package duo_tick_pkg;

  localparam int BUS_W = 32;
  localparam int CTL_W = 11;

  // control word bit positions (software decodes these)
  localparam int CB_MODE   = 0;
  localparam int CB_DOWN   = 1;
  localparam int CB_GENO   = 2;
  localparam int CB_CAPI   = 3;
  localparam int CB_RELOAD = 4;
  localparam int CB_HOLD   = 5;
  localparam int CB_IEN    = 6;
  localparam int CB_RUN    = 7;
  localparam int CB_FLAG   = 8;
  localparam int CB_PWM    = 9;
  localparam int CB_ALL    = 10;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_LOAD = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // packed MSB first, so field order matches the bit positions above
  typedef struct packed {
    logic all;
    logic pwm;
    logic flag;
    logic run;
    logic ien;
    logic hold;
    logic reload;
    logic capi;
    logic geno;
    logic down;
    logic mode;
  } ctl_t;

endpackage

// File: rtl/tick_rst_sync.sv
module tick_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/tick_lane.sv
module tick_lane
  import duo_tick_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             load_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic [CNT_W-1:0] load_wdata,
  input  logic             start_all,
  output ctl_t             ctl_o,
  output logic [CNT_W-1:0] load_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_ONES = '1;
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  ctl_t             ctl_q, ctl_d;
  logic             ctl_en;
  logic [CNT_W-1:0] load_q, load_d;
  logic             load_en;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  logic at_term;
  logic step_en;
  logic hit;

  // terminal detection
  always_comb begin
    at_term = ctl_q.down ? (cnt_q == CNT_ZERO) : (cnt_q == CNT_ONES);
    step_en = ctl_q.run && !ctl_q.hold;
    hit     = step_en && at_term;
  end

  // control word next state
  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we) begin
      ctl_d      = ctl_t'(ctl_wdata);
      ctl_d.flag = ctl_q.flag & ~ctl_wdata[CB_FLAG];
    end else if (hit && !ctl_q.reload) begin
      ctl_d.run = 1'b0;
    end
    if (hit) begin
      ctl_d.flag = 1'b1;
    end
    if (start_all) begin
      ctl_d.run = 1'b1;
    end
    ctl_en = ctl_we | hit | start_all;
  end

  // load register next state
  always_comb begin
    load_d  = load_wdata;
    load_en = load_we;
  end

  // counter next state
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = ctl_q.hold | step_en;
    if (ctl_q.hold) begin
      cnt_d = load_q;
    end else if (step_en) begin
      if (at_term) begin
        cnt_d = ctl_q.reload ? load_q : cnt_q;
      end else if (ctl_q.down) begin
        cnt_d = cnt_q - 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
    end else if (load_en) begin
      load_q <= load_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign ctl_o  = ctl_q;
  assign load_o = load_q;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/tick_rdmux.sv
module tick_rdmux
  import duo_tick_pkg::*;
#(
  parameter int LANES = 2,
  parameter int LB    = 1,
  parameter int AW    = 5
) (
  input  logic [AW-1:0]                addr,
  input  logic [LANES-1:0][BUS_W-1:0]  ctl_w,
  input  logic [LANES-1:0][BUS_W-1:0]  load_w,
  input  logic [LANES-1:0][BUS_W-1:0]  cnt_w,
  output logic [BUS_W-1:0]             rdata
);

  logic [LB-1:0] lane_idx;
  reg_sel_e      sel;
  logic          mapped;

  always_comb begin
    lane_idx = addr[AW-1:4];
    sel      = reg_sel_e'(addr[3:2]);
    mapped   = (addr[1:0] == 2'b00) && ({1'b0, lane_idx} < (LB+1)'(LANES));
    rdata    = '0;
    for (int i = 0; i < LANES; i++) begin
      if (mapped && (lane_idx == LB'(i))) begin
        unique case (sel)
          SEL_CTL:  rdata = ctl_w[i];
          SEL_LOAD: rdata = load_w[i];
          SEL_CNT:  rdata = cnt_w[i];
          SEL_NONE: rdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/duo_tick_timer.sv
module duo_tick_timer
  import duo_tick_pkg::*;
#(
  parameter int  LANES = 2,
  parameter int  CNT_W = 32,
  localparam int LB    = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int AW    = LB + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq
);

  logic rst_sync_n;

  logic [LB-1:0] lane_idx;
  reg_sel_e      reg_sel;
  logic          word_ok;
  logic          start_all;

  logic [LANES-1:0] ctl_we, load_we;
  logic [LANES-1:0] flag_v, ien_v, run_v, hold_v, down_v;
  logic [LANES-1:0][CNT_W-1:0] cnt_v, load_v;
  logic [LANES-1:0][BUS_W-1:0] ctl_w, load_w, cnt_w;

  logic irq_q, irq_d;

  tick_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    lane_idx  = bus_addr[AW-1:4];
    reg_sel   = reg_sel_e'(bus_addr[3:2]);
    word_ok   = (bus_addr[1:0] == 2'b00);
    start_all = (|ctl_we) && bus_wdata[CB_ALL];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic             hit_i;
    ctl_t             ctl_i;
    logic [CTL_W-1:0] ctl_bits;

    assign hit_i      = bus_we && word_ok && (lane_idx == LB'(i));
    assign ctl_we[i]  = hit_i && (reg_sel == SEL_CTL);
    assign load_we[i] = hit_i && (reg_sel == SEL_LOAD);

    tick_lane #(.CNT_W(CNT_W)) u_lane (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .ctl_we     (ctl_we[i]),
      .load_we    (load_we[i]),
      .ctl_wdata  (bus_wdata[CTL_W-1:0]),
      .load_wdata (bus_wdata[CNT_W-1:0]),
      .start_all  (start_all),
      .ctl_o      (ctl_i),
      .load_o     (load_v[i]),
      .cnt_o      (cnt_v[i])
    );

    assign ctl_bits  = ctl_i;
    assign flag_v[i] = ctl_i.flag;
    assign ien_v[i]  = ctl_i.ien;
    assign run_v[i]  = ctl_i.run;
    assign hold_v[i] = ctl_i.hold;
    assign down_v[i] = ctl_i.down;
    assign ctl_w[i]  = BUS_W'(ctl_bits);
    assign load_w[i] = BUS_W'(load_v[i]);
    assign cnt_w[i]  = BUS_W'(cnt_v[i]);
  end

  tick_rdmux #(.LANES(LANES), .LB(LB), .AW(AW)) u_rdmux (
    .addr   (bus_addr),
    .ctl_w  (ctl_w),
    .load_w (load_w),
    .cnt_w  (cnt_w),
    .rdata  (bus_rdata)
  );

  always_comb begin
    irq_d = |(flag_v & ien_v);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/duo_tick_chk.sv
module duo_tick_chk #(
  parameter int LANES = 2,
  parameter int CNT_W = 32,
  parameter int AW    = 5
) (
  input logic                         clk,
  input logic                         rst_sync_n,
  input logic [AW-1:0]                bus_addr,
  input logic                         bus_we,
  input logic [31:0]                  bus_wdata,
  input logic [31:0]                  bus_rdata,
  input logic                         irq,
  input logic [LANES-1:0]             flag_v,
  input logic [LANES-1:0]             ien_v,
  input logic [LANES-1:0]             run_v,
  input logic [LANES-1:0]             hold_v,
  input logic [LANES-1:0]             down_v,
  input logic [LANES-1:0][CNT_W-1:0]  cnt_v,
  input logic [LANES-1:0][CNT_W-1:0]  load_v
);

  localparam int LB = AW - 4;
  localparam logic [CNT_W-1:0] ONES = '1;

  AST_MISALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr[1:0] != 2'b00) |-> (bus_rdata == 32'd0)); // R2

  AST_ALL_START: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(bus_we && bus_wdata[10] && (bus_addr[3:0] == 4'd0) &&
          ({1'b0, bus_addr[AW-1:4]} < (LB+1)'(LANES))) |-> (&run_v)); // R9

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq) |-> $past(|(flag_v & ien_v))); // R10

  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(irq) |-> $past(!(|(flag_v & ien_v)))); // R10

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    AST_HOLD_COPIES: assert property (@(posedge clk) disable iff (!rst_sync_n)
      hold_v[i] |=> (cnt_v[i] == $past(load_v[i]))); // R4

    AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!run_v[i] && !hold_v[i]) |=> $stable(cnt_v[i])); // R5

    AST_FLAG_AT_TERM: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(flag_v[i]) |-> $past(run_v[i] && !hold_v[i] &&
        (cnt_v[i] == (down_v[i] ? '0 : ONES)))); // R6

    AST_FLAG_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $fell(flag_v[i]) |-> $past(bus_we && (bus_addr == AW'(i * 16)) && bus_wdata[8])); // R8
  end

endmodule

bind duo_tick_timer duo_tick_chk #(.LANES(LANES), .CNT_W(CNT_W), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .irq        (irq),
  .flag_v     (flag_v),
  .ien_v      (ien_v),
  .run_v      (run_v),
  .hold_v     (hold_v),
  .down_v     (down_v),
  .cnt_v      (cnt_v),
  .load_v     (load_v)
);

// File: tb/test_duo_tick_timer.sv
`timescale 1ns/100ps
module test_duo_tick_timer;

  logic        clk;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk;
  int n_fail;
  int cyc;

  duo_tick_timer #(.LANES(2), .CNT_W(12)) i_duo_tick_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected at most 200000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    bus_addr = a;
    #0.2;
    chk(req, bus_rdata, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 ctl0", 5'h00, 0);
    rd_chk("R1 load0", 5'h04, 0);
    rd_chk("R1 cnt0", 5'h08, 0);
    rd_chk("R1 ctl1", 5'h10, 0);
    rd_chk("R1 load1", 5'h14, 0);
    rd_chk("R1 cnt1", 5'h18, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_map;
    wr(5'h04, 32'h0000_0ABC);
    wr(5'h14, 32'hFFFF_F123);
    wr(5'h08, 32'h0000_0777);
    wr(5'h00, 32'h0000_020D);
    rd_chk("R2 load0 readback", 5'h04, 32'h0ABC);
    rd_chk("R2 load1 truncated", 5'h14, 32'h0123);
    rd_chk("R2 counter write ignored", 5'h08, 0);
    rd_chk("R11 stored bits readback", 5'h00, 32'h020D);
    rd_chk("R2 offset C", 5'h0C, 0);
    rd_chk("R2 offset 1C", 5'h1C, 0);
    rd_chk("R2 misaligned", 5'h01, 0);
    step(3);
    rd_chk("R11 no counting", 5'h08, 0);
    rd_chk("R12 lane1 ctl untouched", 5'h10, 0);
    wr(5'h00, 32'h0);
  endtask

  task automatic t_down_reload;
    wr(5'h04, 32'd5);
    wr(5'h00, 32'h020);
    wr(5'h00, 32'h0D2);
    rd_chk("R4 hold loaded", 5'h08, 5);
    step(2);
    rd_chk("R3 down count", 5'h08, 3);
    step(3);
    rd_chk("R6 at zero", 5'h08, 0);
    rd_chk("R6 flag not yet", 5'h00, 32'h0D2);
    step(1);
    rd_chk("R6 reloaded", 5'h08, 5);
    rd_chk("R6 flag set", 5'h00, 32'h1D2);
    chk("R10 irq latency", {31'd0, irq}, 0);
    step(1);
    rd_chk("R6 continues", 5'h08, 4);
    chk("R10 irq raised", {31'd0, irq}, 1);
    wr(5'h00, 32'h042);
    rd_chk("R5 stopped value", 5'h08, 3);
    rd_chk("R8 write zero keeps flag", 5'h00, 32'h142);
    step(3);
    rd_chk("R5 holds", 5'h08, 3);
    chk("R10 irq held", {31'd0, irq}, 1);
    wr(5'h00, 32'h142);
    rd_chk("R8 write one clears", 5'h00, 32'h042);
    chk("R10 irq one cycle later", {31'd0, irq}, 1);
    step(1);
    chk("R10 irq dropped", {31'd0, irq}, 0);
    wr(5'h00, 32'h0);
  endtask

  task automatic t_up_stop;
    wr(5'h14, 32'hFFC);
    wr(5'h10, 32'h020);
    wr(5'h10, 32'h080);
    rd_chk("R3 up start", 5'h18, 32'hFFC);
    step(3);
    rd_chk("R3 up reach ones", 5'h18, 32'hFFF);
    rd_chk("R7 still running", 5'h10, 32'h080);
    step(1);
    rd_chk("R7 held at terminal", 5'h18, 32'hFFF);
    rd_chk("R7 run cleared flag set", 5'h10, 32'h100);
    chk("R10 no irq without enable", {31'd0, irq}, 0);
    step(2);
    rd_chk("R7 still held", 5'h18, 32'hFFF);
    rd_chk("R12 lane0 count kept", 5'h08, 3);
    rd_chk("R12 lane0 ctl kept", 5'h00, 0);
    wr(5'h10, 32'h100);
    rd_chk("R8 lane1 cleared", 5'h10, 0);
  endtask

  task automatic t_all;
    wr(5'h14, 32'h010);
    wr(5'h10, 32'h020);
    wr(5'h10, 32'h000);
    rd_chk("R4 lane1 preset", 5'h18, 32'h010);
    wr(5'h00, 32'h402);
    rd_chk("R9 lane0 run", 5'h00, 32'h482);
    rd_chk("R9 lane1 run", 5'h10, 32'h080);
    step(1);
    rd_chk("R9 lane0 counting", 5'h08, 2);
    rd_chk("R9 lane1 counting", 5'h18, 32'h011);
    wr(5'h00, 32'h0);
    wr(5'h10, 32'h0);
  endtask

  task automatic t_up_wrap;
    wr(5'h14, 32'h000);
    wr(5'h10, 32'h020);
    wr(5'h10, 32'h090);
    rd_chk("R4 wrap start", 5'h18, 0);
    step(4095);
    rd_chk("R6 up at ones", 5'h18, 32'hFFF);
    rd_chk("R6 up no flag yet", 5'h10, 32'h090);
    step(1);
    rd_chk("R6 up reload", 5'h18, 0);
    rd_chk("R6 up flag", 5'h10, 32'h190);
    step(1);
    rd_chk("R6 up free run", 5'h18, 1);
    wr(5'h10, 32'h100);
    rd_chk("R8 final clear", 5'h10, 0);
  endtask

  initial begin
    n_chk     = 0;
    n_fail    = 0;
    cyc       = 0;
    rst_n     = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(4);
    t_reset;
    t_map;
    t_down_reload;
    t_up_stop;
    t_all;
    t_up_wrap;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule